// File: doc/BRIEF.md
# Twin-Mask Element Pair Sequencer

This block turns one element-wise instruction into a stream of (source register, destination register) pairs. Two masks control the stream. The source mask selects which source elements are read, and the destination mask selects which destination slots are written. Used together they pack selected elements and then spread them into other positions. With suitable masks and scalar/vector tags, the same loop also gives move, splat, insert and select behaviour.

A one-cycle start pulse captures the element count, both base registers, both vector tags and both masks. The block then walks two independent cursors, one per side. It emits at most one pair per cycle on a valid strobe and pulses done once the sequence ends. The operation applied to each pair, and the register file itself, are outside this block.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset, `valid_o` and `done_o` are low and stay low until a start pulse.
- R2: A start pulse in an idle cycle captures all configuration inputs, and later changes to those inputs do not affect the running sequence. A start pulse while a sequence is running is ignored: the pairs and the done timing of the running sequence are unchanged.
- R3: A vector source whose cursor points at a clear source-mask bit (bit k for element k) advances that cursor by one in that cycle, and no pair is emitted in that cycle.
- R4: The destination side follows the same rule with its own mask. Both cursors may skip in the same cycle, and that cycle emits no pair.
- R5: The register number of a vector operand is base plus cursor, modulo 2^REG_W. The register number of a scalar operand is the base alone, and the mask of a scalar side is ignored.
- R6: After each emitted pair, the source cursor advances by one only when the source is a vector, and the destination cursor advances by one only when the destination is a vector.
- R7: With a scalar destination, the sequence ends after its first emitted pair.
- R8: The sequence ends when either cursor reaches the element count, including while it is skipping. `done_o` is then high for exactly one cycle, in the cycle after the last pair or skip, with `valid_o` low. A count of zero gives done with no pairs.
- R9: An all-ones source mask gives a pure expand (consecutive sources into set destination slots). An all-ones destination mask gives a pure compress (set source elements into consecutive destination slots).
- R10: An element count above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| vl_i | input | $clog2(MAX_VL+1) | Element count |
| src_base_i | input | REG_W | Source base register |
| src_vec_i | input | 1 | Source is a vector |
| src_mask_i | input | MAX_VL | Source element mask |
| dst_base_i | input | REG_W | Destination base register |
| dst_vec_i | input | 1 | Destination is a vector |
| dst_mask_i | input | MAX_VL | Destination slot mask |
| valid_o | output | 1 | Pair valid this cycle |
| src_reg_o | output | REG_W | Source register of the pair |
| dst_reg_o | output | REG_W | Destination register of the pair |
| done_o | output | 1 | Sequence finished, one-cycle pulse |

## Verification
The bench uses the defaults MAX_VL=64 and REG_W=7. With these values a count of 100 reaches the clamp at 64 elements, and a base of 126 shows register numbers wrapping past 127 to 0. Each scenario is compared cycle by cycle against a step model built from the requirements. The model predicts which cycles skip, which emit a pair, and the single cycle that carries done.

// File: rtl/twin_seq_pkg.sv
package twin_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/twin_cursor.sv
module twin_cursor #(
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned REG_W  = 7,
  localparam int unsigned CNT_W = $clog2(MAX_VL + 1),
  localparam int unsigned IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  vl_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [REG_W-1:0]  base_i,
  input  logic              vec_i,
  input  logic              run_i,
  input  logic              step_i,
  output logic              end_o,
  output logic              skip_o,
  output logic              vec_o,
  output logic [REG_W-1:0]  reg_o
);
  logic [CNT_W-1:0]  cnt_q, lim_q;
  logic [MAX_VL-1:0] mask_q;
  logic [REG_W-1:0]  base_q;
  logic              vec_q;
  logic              adv;

  assign end_o  = cnt_q >= lim_q;
  assign skip_o = vec_q && !end_o && !mask_q[cnt_q[IDX_W-1:0]];
  assign vec_o  = vec_q;
  assign reg_o  = vec_q ? base_q + REG_W'(cnt_q) : base_q;
  assign adv    = run_i && (skip_o || (step_i && vec_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      mask_q <= '0;
      base_q <= '0;
      vec_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= '0;
      lim_q  <= (vl_i > CNT_W'(MAX_VL)) ? CNT_W'(MAX_VL) : vl_i;
      mask_q <= mask_i;
      base_q <= base_i;
      vec_q  <= vec_i;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  p_one_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_scalar_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_q && !$past(load_i)) |-> $stable(cnt_q));
  p_vl_clamp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q <= CNT_W'(MAX_VL));
endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq
  import twin_seq_pkg::*;
#(
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned REG_W  = 7,
  localparam int unsigned CNT_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  vl_i,
  input  logic [REG_W-1:0]  src_base_i,
  input  logic              src_vec_i,
  input  logic [MAX_VL-1:0] src_mask_i,
  input  logic [REG_W-1:0]  dst_base_i,
  input  logic              dst_vec_i,
  input  logic [MAX_VL-1:0] dst_mask_i,
  output logic              valid_o,
  output logic [REG_W-1:0]  src_reg_o,
  output logic [REG_W-1:0]  dst_reg_o,
  output logic              done_o
);
  seq_state_e state_q, state_d;
  logic load, running, term, emit, walk;
  logic s_end, s_skip, s_vec, d_end, d_skip, d_vec;

  assign load    = start_i && (state_q == SEQ_IDLE);
  assign running = state_q != SEQ_IDLE;
  assign term    = s_end || d_end || (state_q == SEQ_FIN);
  assign walk    = (state_q == SEQ_RUN) && !term;
  assign emit    = walk && !s_skip && !d_skip;
  assign valid_o = emit;
  assign done_o  = running && term;

  twin_cursor #(.MAX_VL(MAX_VL), .REG_W(REG_W)) u_src (
    .clk_i, .rst_ni, .load_i(load), .vl_i, .mask_i(src_mask_i),
    .base_i(src_base_i), .vec_i(src_vec_i), .run_i(walk), .step_i(emit),
    .end_o(s_end), .skip_o(s_skip), .vec_o(s_vec), .reg_o(src_reg_o));

  twin_cursor #(.MAX_VL(MAX_VL), .REG_W(REG_W)) u_dst (
    .clk_i, .rst_ni, .load_i(load), .vl_i, .mask_i(dst_mask_i),
    .base_i(dst_base_i), .vec_i(dst_vec_i), .run_i(walk), .step_i(emit),
    .end_o(d_end), .skip_o(d_skip), .vec_o(d_vec), .reg_o(dst_reg_o));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (load) state_d = SEQ_RUN;
      SEQ_RUN: begin
        if (term)               state_d = SEQ_IDLE;
        else if (emit && !d_vec) state_d = SEQ_FIN;
      end
      SEQ_FIN:  state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !valid_o));
  p_scalar_dst_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !d_vec) |=> !valid_o);
  p_dst_moves_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && d_vec) |-> (dst_reg_o != $past(dst_reg_o)));
  p_src_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && !s_vec) |-> $stable(src_reg_o));
  p_no_emit_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_skip || s_skip) |-> !valid_o);
endmodule

// File: tb/twin_pred_seq_bench.sv
module twin_pred_seq_bench;
  localparam int CLK_P = 10;
  localparam int MVL = 64;
  localparam int RW = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] vl = '0;
  logic [RW-1:0] sb = '0, db = '0;
  logic sv = 1'b0, dv = 1'b0;
  logic [MVL-1:0] sm = '0, dm = '0;
  logic valid, done;
  logic [RW-1:0] sreg, dreg;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  twin_pred_seq u_twin_pred_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl),
    .src_base_i(sb), .src_vec_i(sv), .src_mask_i(sm),
    .dst_base_i(db), .dst_vec_i(dv), .dst_mask_i(dm),
    .valid_o(valid), .src_reg_o(sreg), .dst_reg_o(dreg), .done_o(done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // runs one sequence against a step model; poke pulses start mid-run
  task automatic run_case(input string tag, input int n, input int s_b, input bit s_v,
                          input logic [MVL-1:0] s_m, input int d_b, input bit d_v,
                          input logic [MVL-1:0] d_m, input bit poke, output int pairs);
    int i = 0, j = 0, lim, steps = 0;
    bit fin = 0, fin_seen = 0;
    lim = (n > MVL) ? MVL : n;
    pairs = 0;
    @(negedge clk);
    start = 1'b1; vl = 7'(n); sb = RW'(s_b); sv = s_v; sm = s_m;
    db = RW'(d_b); dv = d_v; dm = d_m;
    @(negedge clk);
    start = 1'b0; vl = 7'd0; sm = '0; dm = '0; sb = 7'd99; db = 7'd99; // R2 latched
    while (!fin_seen && steps < 300) begin
      bit ev, ss, ds;
      ev = 0;
      if (i >= lim || j >= lim || fin) begin
        chk(done === 1'b1, {tag, " done R8"}, int'(done), 1);
        chk(valid === 1'b0, {tag, " valid at done R8"}, int'(valid), 0);
        fin_seen = 1;
      end else begin
        ss = s_v && !s_m[i];
        ds = d_v && !d_m[j];
        chk(done === 1'b0, {tag, " early done R8"}, int'(done), 0);
        if (ss || ds) begin
          chk(valid === 1'b0, {tag, " skip R3 R4"}, int'(valid), 0);
          i += int'(ss); j += int'(ds);
        end else begin
          chk(valid === 1'b1, {tag, " emit R6"}, int'(valid), 1);
          chk(int'(sreg) == (s_v ? (s_b + i) % 128 : s_b), {tag, " src reg R5"},
              int'(sreg), s_v ? (s_b + i) % 128 : s_b);
          chk(int'(dreg) == (d_v ? (d_b + j) % 128 : d_b), {tag, " dst reg R5"},
              int'(dreg), d_v ? (d_b + j) % 128 : d_b);
          pairs++;
          i += int'(s_v);
          if (d_v) j++; else fin = 1;
        end
      end
      if (poke && steps == 1) begin
        start = 1'b1; vl = 7'd3; sm = '1; dm = '1; sv = 1'b1; dv = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      steps++;
    end
    chk(fin_seen, {tag, " finished R8"}, int'(fin_seen), 1);
    chk(valid === 1'b0 && done === 1'b0, {tag, " idle after R8"}, int'(valid) + int'(done), 0);
  endtask

  task automatic t_reset;
    chk(valid === 1'b0, "reset valid R1", int'(valid), 0);
    chk(done === 1'b0, "reset done R1", int'(done), 0);
  endtask

  task automatic t_compress;
    int p;
    run_case("compress R9", 4, 10, 1, 64'b1010, 20, 1, '1, 0, p);
    chk(p == 2, "compress pairs R9", p, 2);
  endtask

  task automatic t_expand;
    int p;
    run_case("expand R9", 4, 10, 1, '1, 20, 1, 64'b0101, 0, p);
    chk(p == 2, "expand pairs R9", p, 2);
  endtask

  task automatic t_both_skip;
    int p;
    run_case("both skip R4", 4, 1, 1, 64'b1100, 40, 1, 64'b1100, 0, p);
    chk(p == 2, "both skip pairs R4", p, 2);
  endtask

  task automatic t_splat;
    int p;
    run_case("splat R5", 3, 5, 0, '0, 30, 1, '1, 0, p);
    chk(p == 3, "splat pairs R5", p, 3);
  endtask

  task automatic t_select;
    int p;
    run_case("select R7", 4, 8, 1, 64'b0100, 50, 0, '0, 0, p);
    chk(p == 1, "select pairs R7", p, 1);
  endtask

  task automatic t_skip_to_end;
    int p;
    run_case("skip end R8", 3, 2, 1, 64'b0001, 60, 1, '1, 0, p);
    chk(p == 1, "skip end pairs R8", p, 1);
  endtask

  task automatic t_zero;
    int p;
    run_case("vl zero R8", 0, 0, 1, '1, 0, 1, '1, 0, p);
    chk(p == 0, "vl zero pairs R8", p, 0);
  endtask

  task automatic t_wrap;
    int p;
    run_case("wrap R5", 4, 126, 1, '1, 0, 1, '1, 0, p);
    chk(p == 4, "wrap pairs R5", p, 4);
  endtask

  task automatic t_clamp;
    int p;
    run_case("clamp R10", 100, 0, 1, '1, 64, 1, '1, 0, p);
    chk(p == 64, "clamp pairs R10", p, 64);
  endtask

  task automatic t_restart_ignored;
    int p;
    run_case("restart R2", 5, 3, 1, 64'b10110, 70, 1, 64'b11011, 1, p);
    chk(p == 3, "restart pairs R2", p, 3);
  endtask

  task automatic t_scalar_scalar;
    int p;
    run_case("scalar R7", 6, 9, 0, '0, 11, 0, '0, 0, p);
    chk(p == 1, "scalar pairs R7", p, 1);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_compress();
    t_expand();
    t_both_skip();
    t_splat();
    t_select();
    t_skip_to_end();
    t_zero();
    t_wrap();
    t_clamp();
    t_restart_ignored();
    t_scalar_scalar();
    summary();
    $finish;
  end
endmodule